// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block collects 32 external request lines for a single processor core and turns them into one request at a time, together with the index of the line that raised it. The core uses the index to look up a handler. Each line has its own trigger mode: low level, high level, rising edge, falling edge or either edge. Each line also has its own priority number, and a larger number means a more urgent request. Every line is first brought into the clock domain by a two-stage synchroniser. The block then keeps a pending bit for the line and picks a winner among the pending lines that are allowed through.

The core takes a request by pulsing an acknowledge. It reports that a handler has finished by pulsing an end-of-service strobe. The priority of each request that is taken goes onto a four-entry in-service stack. While a handler runs, only a request of strictly higher priority reaches the core, so handlers nest up to four deep.

A single global disable blocks every line except one designated non-maskable line. All settings are written through a simple address/data write port.

Top module: `prioIrqCtrl`

## Requirements
- R1: After reset there is no request. Every line is in level-high mode (code 001) with priority 0, and the global disable is set.
- R2: A write with `cfgAddr` below 32 sets that line's mode from `cfgWdata[2:0]` and its priority from `cfgWdata[5:3]`, and clears its pending state. A write with `cfgAddr` equal to 32 loads the global disable from `cfgWdata[0]`.
- R3: Level modes (000 = pending while the line is low, 001 = pending while it is high) follow the line. An acknowledge does not clear them, and they drop three cycles after the line leaves the level.
- R4: Edge modes (010 = either edge, 011 = rising, 100 = falling) set the pending bit once for each matching transition. The bit holds after the line moves again and is cleared when that line is acknowledged.
- R5: Mode codes 101, 110 and 111 never raise a request.
- R6: A change on a line reaches `irqReq` on the third rising clock edge after it. The first two edges pass it through the synchroniser, and the third edge updates the pending bit.
- R7: Among eligible pending lines, the line with the largest priority number is presented. Among equal priorities, the lowest line index is presented.
- R8: While the global disable is set, only line 31 (the non-maskable line) can raise a request. Edge events on other lines stay pending and appear once the disable is cleared.
- R9: An acknowledge while `irqReq` is high pushes the presented line's priority onto the in-service stack. From then on, only a line with a strictly higher priority produces a request. An acknowledge while `irqReq` is low has no effect.
- R10: An end-of-service pulse pops the stack, so the previous nesting level again decides which lines can request. An end-of-service pulse with an empty stack has no effect.
- R11: With four requests in service, no further request is raised, whatever its priority, until an end-of-service pulse arrives.
- R12: Whenever `irqReq` is high, `irqVec` holds the index of a line whose pending bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineIn | input | 32 | External request lines, asynchronous |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | Write address: line 0..31, or 32 for the global disable |
| cfgWdata | input | 6 | Write data: mode [2:0] and priority [5:3], or disable in bit 0 |
| irqAck | input | 1 | Core takes the presented request (one-cycle pulse) |
| irqEos | input | 1 | Core finished the innermost handler (one-cycle pulse) |
| irqReq | output | 1 | Request to the core |
| irqVec | output | 5 | Index of the presented line |

## Verification
A change on `lineIn` reaches `irqReq` and `irqVec` on the third rising edge after it, so the bench checks both one negative edge after that third rising edge. It also checks one edge earlier that nothing has appeared yet. Configuration writes, acknowledges and end-of-service pulses act on the very next rising edge, because selection and the request decision are combinational from registered state. Checks of their effect are therefore sampled at the next negative edge.

// File: rtl/irqPkg.sv
package irqPkg;

  typedef enum logic [2:0] {
    TRIG_LOW  = 3'b000,
    TRIG_HIGH = 3'b001,
    TRIG_ANY  = 3'b010,
    TRIG_RISE = 3'b011,
    TRIG_FALL = 3'b100
  } trigMode_e;

  // strobes from the service control into the datapath
  typedef struct packed {
    logic ackFire;
    logic eosFire;
  } svcStrobe_t;

endpackage

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 3,
  parameter int NMI_LINE  = 31,
  localparam int ADDR_W   = $clog2(NUM_LINES + 1),
  localparam int VEC_W    = $clog2(NUM_LINES),
  localparam int CFG_W    = 3 + PRIO_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 cfgWe,
  input  logic [ADDR_W-1:0]    cfgAddr,
  input  logic [CFG_W-1:0]     cfgWdata,
  input  svcStrobe_t           strobe,
  output logic                 bestFound,
  output logic [VEC_W-1:0]     bestIdx,
  output logic [PRIO_W-1:0]    bestPrio,
  output logic [NUM_LINES-1:0] pendVec,
  output logic                 globalDis
);

  logic [NUM_LINES-1:0] syncA, syncB, prevB;
  logic [NUM_LINES-1:0] riseVec, fallVec, clrVec, nextPend, eligible;
  logic [2:0]           modeReg [NUM_LINES];
  logic [PRIO_W-1:0]    prioReg [NUM_LINES];
  logic [NUM_LINES-1:0] unmaskVec;

  // two-flop synchroniser and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign riseVec = syncB & ~prevB;
  assign fallVec = ~syncB & prevB;

  // one-hot clear of the acknowledged line, and the unmaskable-line mask
  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : gLine
      assign clrVec[g]    = strobe.ackFire && (bestIdx == VEC_W'(g));
      assign unmaskVec[g] = (g == NMI_LINE);
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      case (modeReg[i])
        TRIG_LOW:  nextPend[i] = ~syncB[i];
        TRIG_HIGH: nextPend[i] = syncB[i];
        TRIG_ANY:  nextPend[i] = riseVec[i] | fallVec[i] | (pendVec[i] & ~clrVec[i]);
        TRIG_RISE: nextPend[i] = riseVec[i] | (pendVec[i] & ~clrVec[i]);
        TRIG_FALL: nextPend[i] = fallVec[i] | (pendVec[i] & ~clrVec[i]);
        default:   nextPend[i] = 1'b0;
      endcase
    end
  end

  // configuration and pending state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalDis <= 1'b1;
      pendVec   <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        modeReg[i] <= TRIG_HIGH;
        prioReg[i] <= '0;
      end
    end else begin
      if (cfgWe && cfgAddr == ADDR_W'(NUM_LINES)) globalDis <= cfgWdata[0];
      for (int i = 0; i < NUM_LINES; i++) begin
        if (cfgWe && cfgAddr == ADDR_W'(i)) begin
          modeReg[i] <= cfgWdata[2:0];
          prioReg[i] <= cfgWdata[3 +: PRIO_W];
          pendVec[i] <= 1'b0;
        end else begin
          pendVec[i] <= nextPend[i];
        end
      end
    end
  end

  // winner selection: highest priority, lowest index on ties
  assign eligible = pendVec & (globalDis ? unmaskVec : {NUM_LINES{1'b1}});

  always_comb begin
    bestFound = 1'b0;
    bestIdx   = '0;
    bestPrio  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (eligible[i] && (!bestFound || prioReg[i] >= bestPrio)) begin
        bestFound = 1'b1;
        bestIdx   = VEC_W'(i);
        bestPrio  = prioReg[i];
      end
    end
  end

endmodule

// File: rtl/irqControl.sv
module irqControl
  import irqPkg::*;
#(
  parameter int PRIO_W     = 3,
  parameter int NEST_DEPTH = 4,
  localparam int CNT_W     = $clog2(NEST_DEPTH + 1),
  localparam int SLOT_W    = (NEST_DEPTH > 1) ? $clog2(NEST_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqAck,
  input  logic              irqEos,
  input  logic              bestFound,
  input  logic [PRIO_W-1:0] bestPrio,
  output logic              irqReq,
  output svcStrobe_t        strobe,
  output logic [CNT_W-1:0]  stackCnt
);

  logic [PRIO_W-1:0] prioStack [NEST_DEPTH];
  logic [PRIO_W-1:0] topPrio;
  logic              stackEmpty, stackFull;

  assign stackEmpty = (stackCnt == '0);
  assign stackFull  = (stackCnt == CNT_W'(NEST_DEPTH));
  assign topPrio    = stackEmpty ? '0 : prioStack[SLOT_W'(stackCnt - CNT_W'(1))];

  assign irqReq = bestFound && !stackFull && (stackEmpty || bestPrio > topPrio);

  assign strobe.ackFire = irqAck && irqReq;
  assign strobe.eosFire = irqEos && !stackEmpty && !strobe.ackFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackCnt <= '0;
      for (int i = 0; i < NEST_DEPTH; i++) prioStack[i] <= '0;
    end else if (strobe.ackFire) begin
      prioStack[SLOT_W'(stackCnt)] <= bestPrio;
      stackCnt <= stackCnt + CNT_W'(1);
    end else if (strobe.eosFire) begin
      stackCnt <= stackCnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/prioIrqCtrl.sv
module prioIrqCtrl
  import irqPkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int PRIO_W     = 3,
  parameter int NEST_DEPTH = 4,
  parameter int NMI_LINE   = 31,
  localparam int ADDR_W    = $clog2(NUM_LINES + 1),
  localparam int VEC_W     = $clog2(NUM_LINES),
  localparam int CFG_W     = 3 + PRIO_W,
  localparam int CNT_W     = $clog2(NEST_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 cfgWe,
  input  logic [ADDR_W-1:0]    cfgAddr,
  input  logic [CFG_W-1:0]     cfgWdata,
  input  logic                 irqAck,
  input  logic                 irqEos,
  output logic                 irqReq,
  output logic [VEC_W-1:0]     irqVec
);

  svcStrobe_t           strobe;
  logic                 bestFound;
  logic [VEC_W-1:0]     bestIdx;
  logic [PRIO_W-1:0]    bestPrio;
  logic [NUM_LINES-1:0] pendVec;
  logic                 globalDis;
  logic [CNT_W-1:0]     stackCnt;

  irqDatapath #(
    .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .NMI_LINE(NMI_LINE)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .strobe(strobe), .bestFound(bestFound), .bestIdx(bestIdx),
    .bestPrio(bestPrio), .pendVec(pendVec), .globalDis(globalDis)
  );

  irqControl #(
    .PRIO_W(PRIO_W), .NEST_DEPTH(NEST_DEPTH)
  ) u_control (
    .clk(clk), .rstN(rstN), .irqAck(irqAck), .irqEos(irqEos),
    .bestFound(bestFound), .bestPrio(bestPrio),
    .irqReq(irqReq), .strobe(strobe), .stackCnt(stackCnt)
  );

  assign irqVec = bestIdx;

endmodule

// File: rtl/irqChecker.sv
module irqChecker #(
  parameter int NUM_LINES  = 32,
  parameter int NEST_DEPTH = 4,
  parameter int NMI_LINE   = 31,
  localparam int VEC_W     = $clog2(NUM_LINES),
  localparam int CNT_W     = $clog2(NEST_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 irqReq,
  input logic [VEC_W-1:0]     irqVec,
  input logic                 irqAck,
  input logic                 irqEos,
  input logic [NUM_LINES-1:0] pendVec,
  input logic                 globalDis,
  input logic [CNT_W-1:0]     stackCnt
);

  AST_REQ_HAS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> pendVec[irqVec]); // R12

  AST_MASK_ONLY_NMI: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && globalDis) |-> (irqVec == VEC_W'(NMI_LINE))); // R8

  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq) |=> (stackCnt == $past(stackCnt) + CNT_W'(1))); // R9

  AST_IDLE_ACK_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !irqReq && !irqEos) |=> (stackCnt == $past(stackCnt))); // R9

  AST_EOS_POPS: assert property (@(posedge clk) disable iff (!rstN)
    (irqEos && !irqAck && stackCnt != '0) |=> (stackCnt == $past(stackCnt) - CNT_W'(1))); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (stackCnt <= CNT_W'(NEST_DEPTH))); // R11

  AST_FULL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (stackCnt == CNT_W'(NEST_DEPTH)) |-> !irqReq); // R11

endmodule

bind prioIrqCtrl irqChecker #(
  .NUM_LINES(NUM_LINES), .NEST_DEPTH(NEST_DEPTH), .NMI_LINE(NMI_LINE)
) u_irqChecker (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqVec(irqVec),
  .irqAck(irqAck), .irqEos(irqEos), .pendVec(pendVec),
  .globalDis(globalDis), .stackCnt(stackCnt)
);

// File: tb/prioIrqCtrl_bench.sv
`timescale 1ns/1ps
module prioIrqCtrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lineIn = '0;
  logic        cfgWe = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [5:0]  cfgWdata = '0;
  logic        irqAck = 1'b0;
  logic        irqEos = 1'b0;
  logic        irqReq;
  logic [4:0]  irqVec;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  int rndPrio [32];

  always #2 clk = ~clk;

  prioIrqCtrl u_prioIrqCtrl (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .irqAck(irqAck),
    .irqEos(irqEos), .irqReq(irqReq), .irqVec(irqVec)
  );

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgWrite(input int addr, input int mode, input int prio);
    cfgWe    = 1'b1;
    cfgAddr  = 6'(addr);
    cfgWdata = 6'((prio << 3) | mode);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setDisable(input bit d);
    cfgWe    = 1'b1;
    cfgAddr  = 6'd32;
    cfgWdata = 6'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseAck();
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic pulseEos();
    irqEos = 1'b1;
    @(negedge clk);
    irqEos = 1'b0;
  endtask

  task automatic expectReq(input string tag, input bit er, input int ev);
    vectors++;
    if (irqReq !== er || (er && int'(irqVec) != ev)) begin
      fails++;
      $display("FAIL %s: req=%0b vec=%0d expected req=%0b vec=%0d",
               tag, irqReq, irqVec, er, ev);
    end
  endtask

  function automatic void bestOf(input logic [31:0] pat, output bit f, output int idx);
    int bp;
    bp = -1;
    f = 0;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (pat[i] && rndPrio[i] >= bp) begin
        f = 1;
        idx = i;
        bp = rndPrio[i];
      end
    end
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit ef;
    int ei;
    void'($urandom(32'd20240611));
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    expectReq("R1 reset idle", 0, 0);

    // R1/R8: reset disable set; only non-maskable line 31 passes
    lineIn[5] = 1'b1;
    waitN(4);
    expectReq("R8 masked line 5", 0, 0);
    lineIn[31] = 1'b1;
    waitN(2);
    expectReq("R6 not yet after two edges", 0, 0);
    waitN(1);
    expectReq("R8 nmi bypass, R1 default level-high", 1, 31);
    lineIn[31] = 1'b0;
    waitN(3);
    expectReq("R3 level drops, masked line 5 still blocked", 0, 0);
    setDisable(0);
    expectReq("R1 default mode on line 5 after enable", 1, 5);
    lineIn[5] = 1'b0;
    waitN(3);
    expectReq("R3 line 5 released", 0, 0);

    // R3: level-low
    cfgWrite(7, 0, 2);
    waitN(3);
    expectReq("R3 level-low active", 1, 7);
    lineIn[7] = 1'b1;
    waitN(3);
    expectReq("R3 level-low released", 0, 0);

    // R4/R6: rising
    cfgWrite(8, 3, 1);
    lineIn[8] = 1'b1;
    waitN(2);
    expectReq("R6 rise not yet", 0, 0);
    waitN(1);
    expectReq("R6 rise on third edge", 1, 8);
    lineIn[8] = 1'b0;
    waitN(3);
    expectReq("R4 rise pending held", 1, 8);
    pulseAck();
    expectReq("R4 rise cleared by ack", 0, 0);
    pulseEos();
    expectReq("R4 still clear after eos", 0, 0);

    // R4: falling
    cfgWrite(9, 4, 1);
    lineIn[9] = 1'b1;
    waitN(4);
    expectReq("R4 fall ignores rise", 0, 0);
    lineIn[9] = 1'b0;
    waitN(3);
    expectReq("R4 fall detected", 1, 9);
    pulseAck();
    pulseEos();
    expectReq("R4 fall cleared", 0, 0);

    // R4: either edge
    cfgWrite(10, 2, 1);
    lineIn[10] = 1'b1;
    waitN(3);
    expectReq("R4 any-edge rise", 1, 10);
    pulseAck();
    pulseEos();
    expectReq("R4 any-edge cleared", 0, 0);
    lineIn[10] = 1'b0;
    waitN(3);
    expectReq("R4 any-edge fall", 1, 10);
    pulseAck();
    pulseEos();

    // R5: reserved codes
    cfgWrite(11, 5, 7);
    cfgWrite(1, 6, 7);
    cfgWrite(2, 7, 7);
    lineIn[11] = 1'b1; lineIn[1] = 1'b1; lineIn[2] = 1'b1;
    waitN(4);
    expectReq("R5 reserved high", 0, 0);
    lineIn[11] = 1'b0; lineIn[1] = 1'b0; lineIn[2] = 1'b0;
    waitN(4);
    expectReq("R5 reserved low", 0, 0);

    // R9/R10/R11: nesting
    for (int i = 12; i <= 18; i++) cfgWrite(i, 1, (i == 14) ? 2 : (i == 15) ? 1 :
                                           (i == 16) ? 3 : (i == 17) ? 4 : (i == 18) ? 6 : 0);
    pulseAck();
    lineIn[12] = 1'b1;
    waitN(3);
    expectReq("R9 idle ack ignored", 1, 12);
    pulseAck();
    expectReq("R9 level stays but not re-presented", 0, 0);
    lineIn[13] = 1'b1;
    waitN(3);
    expectReq("R9 equal priority blocked", 0, 0);
    lineIn[14] = 1'b1;
    waitN(3);
    expectReq("R9 higher priority nests", 1, 14);
    pulseAck();
    lineIn[14] = 1'b0;
    lineIn[15] = 1'b1;
    waitN(3);
    expectReq("R9 lower priority blocked", 0, 0);
    pulseEos();
    expectReq("R10 pop restores level", 1, 15);
    pulseAck();
    lineIn[16] = 1'b1;
    waitN(3);
    expectReq("R9 third level", 1, 16);
    pulseAck();
    lineIn[17] = 1'b1;
    waitN(3);
    expectReq("R9 fourth level", 1, 17);
    pulseAck();
    lineIn[18] = 1'b1;
    waitN(3);
    expectReq("R11 stack full blocks", 0, 0);
    pulseEos();
    expectReq("R11 resumes after pop", 1, 18);
    for (int i = 12; i <= 18; i++) lineIn[i] = 1'b0;
    waitN(3);
    pulseEos(); pulseEos(); pulseEos();
    pulseEos(); pulseEos();
    lineIn[12] = 1'b1;
    waitN(3);
    expectReq("R10 eos on empty stack ignored", 1, 12);
    lineIn[12] = 1'b0;
    waitN(3);

    // R7: tie on priority
    cfgWrite(19, 1, 4);
    cfgWrite(20, 1, 5);
    cfgWrite(21, 1, 5);
    lineIn[19] = 1'b1; lineIn[20] = 1'b1; lineIn[21] = 1'b1;
    waitN(3);
    expectReq("R7 tie lower index", 1, 20);
    lineIn[20] = 1'b0;
    waitN(3);
    expectReq("R7 next by priority", 1, 21);
    lineIn[19] = 1'b0; lineIn[21] = 1'b0;
    waitN(3);

    // R2: write clears pending
    cfgWrite(22, 3, 1);
    lineIn[22] = 1'b1;
    waitN(3);
    expectReq("R2 rise pending", 1, 22);
    cfgWrite(22, 3, 1);
    expectReq("R2 config write clears pending", 0, 0);
    lineIn[22] = 1'b0;

    // R8: edge held while masked
    setDisable(1);
    cfgWrite(23, 3, 1);
    lineIn[23] = 1'b1;
    waitN(4);
    expectReq("R8 edge masked", 0, 0);
    setDisable(0);
    expectReq("R8 edge appears after enable", 1, 23);
    pulseAck();
    pulseEos();
    lineIn[23] = 1'b0;
    lineIn[7] = 1'b0;
    waitN(3);

    // R7/R12: random priorities, level-high patterns
    for (int it = 0; it < 30; it++) begin
      for (int i = 0; i < 32; i++) begin
        rndPrio[i] = int'($urandom_range(7, 0));
        cfgWrite(i, 1, rndPrio[i]);
      end
      for (int p = 0; p < 4; p++) begin
        lineIn = $urandom & $urandom & $urandom;
        waitN(3);
        bestOf(lineIn, ef, ei);
        expectReq("R7 random selection", ef, ei);
      end
      lineIn = '0;
      waitN(3);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule